// File: doc/BRIEF.md
# Programmable Parallel Bus Cycle Sequencer

This block runs one bus cycle at a time on an external parallel memory bus. A requester hands over a 16-bit address, a read/write flag, write data and a flag that says whether the upper address byte should be driven. The block then steps through the phases of the cycle and drives the strobes, the address and the data pins. Each pin group has its own output enable. When the cycle ends, the block raises a one-clock done pulse and presents the byte captured on a read.

Two bus shapes are supported. In multiplexed mode the low address byte and the data share one 8-bit pin group. A latch-enable pulse marks the address phase, and an equally long low phase follows it. In separate mode the low address has its own pins and the latch enable stays low. The widths of the address setup, the strobe, the address hold and the latch-enable phases are set in system clocks by configuration fields. Short settings are stretched to a minimum cycle length for each mode. Between cycles every output enable is low, so the port logic keeps control of the pins.

Top module: `pbus_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `ale` is 0, `rd_n` and `wr_n` are 1, and all four output enables (`ctl_oe`, `addr_hi_oe`, `addr_lo_oe`, `ad_oe`) are 0.
- R2: With `cfg_sep`=0 (multiplexed), a cycle opens with `ale`=1 for `cfg_ale`+1 clocks. It is followed by `ale`=0 for `cfg_ale`+1 clocks. In both of these phases `ad_oe`=1 and `ad_o` carries address bits 7:0, and `addr_lo_oe` stays 0 for the whole cycle. With `cfg_sep`=1 (separate), `ale` stays 0, and `addr_lo_oe`=1 with `addr_lo_o` = address bits 7:0 for the whole cycle.
- R3: The strobe asserts `cfg_setup` clocks (0..3) after the address phase ends. In separate mode the address phase is empty, so the strobe asserts `cfg_setup` clocks after the first cycle clock. In multiplexed mode it asserts `cfg_setup` clocks after the end of the latch-enable low phase, and `ad_o` keeps the low address with `ad_oe`=1 during those setup clocks.
- R4: `req_write`=1 selects a write and `req_write`=0 a read. The matching active-low strobe (`wr_n` or `rd_n`) is low for exactly `cfg_strobe`+1 consecutive clocks (1..16), and the two strobes are never low together.
- R5: After the strobe rises, the cycle lasts at least `cfg_hold` more clocks (0..3). The total number of clocks with `busy` high equals the larger of the natural length and the mode minimum. The natural length is 2·(`cfg_ale`+1) in multiplexed mode only, plus `cfg_setup` + `cfg_strobe`+1 + `cfg_hold`.
- R6: The minimum cycle length is 5 clocks in separate mode and 7 clocks in multiplexed mode. Short settings are padded at the end of the cycle with both strobes high.
- R7: On a read, `ad_oe` is 0 from the strobe to the end of the cycle (and for the whole cycle in separate mode). The byte on `ad_i` during the last strobe clock appears on `rdata` while `done` is high.
- R8: On a write, `ad_o` carries the write data with `ad_oe`=1 from the strobe to the end of the cycle. In separate mode this holds for the whole cycle.
- R9: `done` is a one-clock pulse in the first clock after the cycle, with `busy` low. A request is taken only when `busy` is low. A request raised while `busy` is high is ignored, and a request held high through `done` starts the next cycle in the clock after `done`.
- R10: `addr_hi_oe` equals `req_hi_drv` for every clock of a cycle, and `addr_hi_o` carries address bits 15:8 throughout.
- R11: Address, data, flags and all configuration fields are sampled when a request is taken. Changes to the configuration inputs during a cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi_drv | input | 1 | Drive the upper address byte during the cycle |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| cfg_sep | input | 1 | 0 = multiplexed address/data, 1 = separate pins |
| cfg_ale | input | 2 | Latch-enable high and low width, code+1 clocks |
| cfg_setup | input | 2 | Address setup clocks before the strobe |
| cfg_strobe | input | 4 | Strobe width, code+1 clocks |
| cfg_hold | input | 2 | Address hold clocks after the strobe |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Byte captured on the last read strobe clock |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Output enable for the control pins |
| addr_hi_o | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Output enable for the upper address pins |
| addr_lo_o | output | 8 | Low address byte (separate mode) |
| addr_lo_oe | output | 1 | Output enable for the low address pins |
| ad_o | output | 8 | Data, or multiplexed low address, out |
| ad_oe | output | 1 | Output enable for the data pins |
| ad_i | input | 8 | Data pins in |

## Verification
The hardest situations to reach from the ports are the cycles whose natural length falls below the mode minimum, where padding must follow the hold phase, and requests or configuration changes that land while a cycle is running. The stimulus table mixes all-zero timing codes in both modes with maximum codes and settings that fall just one clock short of the minimum. Directed tests then pulse a second request and rewrite the configuration in the middle of a long cycle. A further test holds a request high across `done` to check that the next cycle starts at once. The bench drives `ad_i` to the expected byte only while `rd_n` is low, so a capture taken in the wrong clock shows up.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int ALE_W = 2;
    localparam int SET_W = 2;
    localparam int STB_W = 4;
    localparam int HLD_W = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE_HI,
        PH_ALE_LO,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_PAD
    } phase_e;

    typedef struct packed {
        logic             sep;
        logic [ALE_W-1:0] ale;
        logic [SET_W-1:0] setup;
        logic [STB_W-1:0] strobe;
        logic [HLD_W-1:0] hold;
    } bus_cfg_t;

endpackage

// File: rtl/pbus_fsm.sv
module pbus_fsm
    import pbus_pkg::*;
#(
    parameter int MIN_SEP = 5,
    parameter int MIN_MUX = 7
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  bus_cfg_t cfg_in,
    output phase_e   phase,
    output bus_cfg_t cfg,
    output logic     last_strobe,
    output logic     done
);

    localparam int CNT_W   = STB_W;
    localparam int MAX_LEN = 2 * (2 ** ALE_W) + (2 ** SET_W) + (2 ** STB_W)
                             + (2 ** HLD_W) + MIN_SEP + MIN_MUX;
    localparam int EL_W    = $clog2(MAX_LEN + 1);

    typedef struct packed {
        phase_e          phase;
        bus_cfg_t        cfg;
        logic [CNT_W-1:0] cnt;
        logic [EL_W-1:0]  el;
        logic             done;
    } fsm_t;

    fsm_t s_d, s_q;
    logic [EL_W-1:0] min_len;
    logic            finish;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        min_len  = s_q.cfg.sep ? EL_W'(MIN_SEP) : EL_W'(MIN_MUX);
        finish   = (s_q.el + EL_W'(1)) >= min_len;
        if (s_q.phase != PH_IDLE) begin
            s_d.el = s_q.el + EL_W'(1);
        end
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.cfg = cfg_in;
                    s_d.el  = '0;
                    if (!cfg_in.sep) begin
                        s_d.phase = PH_ALE_HI;
                        s_d.cnt   = CNT_W'(cfg_in.ale);
                    end else if (cfg_in.setup != '0) begin
                        s_d.phase = PH_SETUP;
                        s_d.cnt   = CNT_W'(cfg_in.setup - 1'b1);
                    end else begin
                        s_d.phase = PH_STROBE;
                        s_d.cnt   = CNT_W'(cfg_in.strobe);
                    end
                end
            end
            PH_PAD: begin
                if (finish) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else begin
                    unique case (s_q.phase)
                        PH_ALE_HI: begin
                            s_d.phase = PH_ALE_LO;
                            s_d.cnt   = CNT_W'(s_q.cfg.ale);
                        end
                        PH_ALE_LO: begin
                            if (s_q.cfg.setup != '0) begin
                                s_d.phase = PH_SETUP;
                                s_d.cnt   = CNT_W'(s_q.cfg.setup - 1'b1);
                            end else begin
                                s_d.phase = PH_STROBE;
                                s_d.cnt   = CNT_W'(s_q.cfg.strobe);
                            end
                        end
                        PH_SETUP: begin
                            s_d.phase = PH_STROBE;
                            s_d.cnt   = CNT_W'(s_q.cfg.strobe);
                        end
                        PH_STROBE: begin
                            if (s_q.cfg.hold != '0) begin
                                s_d.phase = PH_HOLD;
                                s_d.cnt   = CNT_W'(s_q.cfg.hold - 1'b1);
                            end else if (finish) begin
                                s_d.phase = PH_IDLE;
                                s_d.done  = 1'b1;
                            end else begin
                                s_d.phase = PH_PAD;
                            end
                        end
                        default: begin
                            if (finish) begin
                                s_d.phase = PH_IDLE;
                                s_d.done  = 1'b1;
                            end else begin
                                s_d.phase = PH_PAD;
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cfg: '0, cnt: '0, el: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase       = s_q.phase;
    assign cfg         = s_q.cfg;
    assign done        = s_q.done;
    assign last_strobe = (s_q.phase == PH_STROBE) && (s_q.cnt == '0);

endmodule

// File: rtl/pbus_req.sv
module pbus_req #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              last_strobe,
    input  logic              req_write,
    input  logic              req_hi_drv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_i,
    output logic [ADDR_W-1:0] addr,
    output logic              wr,
    output logic              hi,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              hi;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } req_t;

    req_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.addr  = req_addr;
            r_d.wr    = req_write;
            r_d.hi    = req_hi_drv;
            r_d.wdata = req_wdata;
        end
        if (last_strobe && !r_q.wr) begin
            r_d.rdata = ad_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr  = r_q.addr;
    assign wr    = r_q.wr;
    assign hi    = r_q.hi;
    assign wdata = r_q.wdata;
    assign rdata = r_q.rdata;

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  logic              sep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              hi,
    input  logic [DATA_W-1:0] wdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ctl_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic              addr_hi_oe,
    output logic [DATA_W-1:0] addr_lo_o,
    output logic              addr_lo_oe,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe
);

    logic active;
    logic strobe;
    logic addr_phase;

    always_comb begin
        active     = (phase != PH_IDLE);
        strobe     = (phase == PH_STROBE);
        addr_phase = (phase == PH_ALE_HI) || (phase == PH_ALE_LO) || (phase == PH_SETUP);

        ale        = (phase == PH_ALE_HI);
        rd_n       = !(strobe && !wr);
        wr_n       = !(strobe && wr);
        ctl_oe     = active;

        addr_hi_o  = active ? addr[ADDR_W-1:DATA_W] : '0;
        addr_hi_oe = active && hi;

        addr_lo_o  = (active && sep) ? addr[DATA_W-1:0] : '0;
        addr_lo_oe = active && sep;

        ad_o  = '0;
        ad_oe = 1'b0;
        if (active) begin
            if (!sep && addr_phase) begin
                ad_o  = addr[DATA_W-1:0];
                ad_oe = 1'b1;
            end else if (wr) begin
                ad_o  = wdata;
                ad_oe = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int MIN_SEP = 5,
    parameter int MIN_MUX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_hi_drv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_sep,
    input  logic [ALE_W-1:0]  cfg_ale,
    input  logic [SET_W-1:0]  cfg_setup,
    input  logic [STB_W-1:0]  cfg_strobe,
    input  logic [HLD_W-1:0]  cfg_hold,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ctl_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic              addr_hi_oe,
    output logic [DATA_W-1:0] addr_lo_o,
    output logic              addr_lo_oe,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_i
);

    phase_e            phase;
    bus_cfg_t          cfg_now;
    bus_cfg_t          cfg_cur;
    logic              start;
    logic              last_strobe;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_wr;
    logic              cur_hi;
    logic [DATA_W-1:0] cur_wdata;

    assign cfg_now = '{sep: cfg_sep, ale: cfg_ale, setup: cfg_setup,
                       strobe: cfg_strobe, hold: cfg_hold};
    assign busy    = (phase != PH_IDLE);
    assign start   = req_valid && !busy;

    pbus_fsm #(
        .MIN_SEP (MIN_SEP),
        .MIN_MUX (MIN_MUX)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_in      (cfg_now),
        .phase       (phase),
        .cfg         (cfg_cur),
        .last_strobe (last_strobe),
        .done        (done)
    );

    pbus_req #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .last_strobe (last_strobe),
        .req_write   (req_write),
        .req_hi_drv  (req_hi_drv),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ad_i        (ad_i),
        .addr        (cur_addr),
        .wr          (cur_wr),
        .hi          (cur_hi),
        .wdata       (cur_wdata),
        .rdata       (rdata)
    );

    pbus_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .phase      (phase),
        .sep        (cfg_cur.sep),
        .addr       (cur_addr),
        .wr         (cur_wr),
        .hi         (cur_hi),
        .wdata      (cur_wdata),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ctl_oe     (ctl_oe),
        .addr_hi_o  (addr_hi_o),
        .addr_hi_oe (addr_hi_oe),
        .addr_lo_o  (addr_lo_o),
        .addr_lo_oe (addr_lo_oe),
        .ad_o       (ad_o),
        .ad_oe      (ad_oe)
    );

endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic ctl_oe,
    input logic addr_hi_oe,
    input logic addr_lo_oe,
    input logic ad_oe
);

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ctl_oe && !addr_hi_oe && !addr_lo_oe && !ad_oe && rd_n && wr_n && !ale));

    p_ale_quiet_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && !addr_lo_oe));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_strobe_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> busy);

    p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hi_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_hi_oe));

endmodule

bind pbus_seq pbus_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ctl_oe     (ctl_oe),
    .addr_hi_oe (addr_hi_oe),
    .addr_lo_oe (addr_lo_oe),
    .ad_oe      (ad_oe)
);

// File: tb/pbus_seq_tb.sv
`timescale 1ns/1ps
module pbus_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_hi_drv = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        cfg_sep = 1'b0;
    logic [1:0]  cfg_ale = '0;
    logic [1:0]  cfg_setup = '0;
    logic [3:0]  cfg_strobe = '0;
    logic [1:0]  cfg_hold = '0;
    logic        busy, done, ale, rd_n, wr_n, ctl_oe;
    logic        addr_hi_oe, addr_lo_oe, ad_oe;
    logic [7:0]  rdata, addr_hi_o, addr_lo_o, ad_o, ad_i;
    logic [7:0]  cur_rv = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign ad_i = rd_n ? ~cur_rv : cur_rv;

    pbus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_hi_drv(req_hi_drv), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_sep(cfg_sep), .cfg_ale(cfg_ale), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .busy(busy), .done(done),
        .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe),
        .addr_hi_o(addr_hi_o), .addr_hi_oe(addr_hi_oe), .addr_lo_o(addr_lo_o),
        .addr_lo_oe(addr_lo_oe), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i)
    );

    typedef struct packed {
        logic        sep;
        logic [1:0]  a;
        logic [1:0]  s;
        logic [3:0]  w;
        logic [1:0]  h;
        logic        wr;
        logic        hi;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  rv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd0, 4'd0,  2'd0, 1'b0, 1'b1, 16'h1234, 8'h00, 8'hA5},
        '{1'b1, 2'd0, 2'd0, 4'd0,  2'd0, 1'b1, 1'b0, 16'h00FF, 8'h3C, 8'h00},
        '{1'b1, 2'd0, 2'd3, 4'd15, 2'd3, 1'b0, 1'b1, 16'hC081, 8'h00, 8'h69},
        '{1'b0, 2'd3, 2'd2, 4'd4,  2'd1, 1'b1, 1'b1, 16'h8E42, 8'hD7, 8'h00},
        '{1'b0, 2'd1, 2'd1, 4'd1,  2'd3, 1'b0, 1'b0, 16'h55AA, 8'h00, 8'h0F},
        '{1'b1, 2'd0, 2'd1, 4'd2,  2'd0, 1'b1, 1'b1, 16'h7F01, 8'h81, 8'h00},
        '{1'b0, 2'd2, 2'd0, 4'd7,  2'd2, 1'b1, 1'b0, 16'h0310, 8'hE4, 8'h00},
        '{1'b1, 2'd0, 2'd0, 4'd3,  2'd2, 1'b0, 1'b0, 16'hFFFE, 8'h00, 8'hC3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input vec_t v);
        cfg_sep = v.sep; cfg_ale = v.a; cfg_setup = v.s;
        cfg_strobe = v.w; cfg_hold = v.h;
        req_write = v.wr; req_hi_drv = v.hi; req_addr = v.addr;
        req_wdata = v.wd; cur_rv = v.rv;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int pre_e, stw_e, nat, len_e, ale_e;
        int len, ale_c, pre, stw, bad, guard;
        bit seen;
        pre_e = (v.sep ? 0 : 2 * (int'(v.a) + 1)) + int'(v.s);
        stw_e = int'(v.w) + 1;
        nat   = pre_e + stw_e + int'(v.h);
        len_e = (nat > (v.sep ? 5 : 7)) ? nat : (v.sep ? 5 : 7);
        ale_e = v.sep ? 0 : int'(v.a) + 1;
        len = 0; ale_c = 0; pre = 0; stw = 0; bad = 0; seen = 1'b0; guard = 0;
        @(negedge clk);
        set_cfg(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && guard < 100) begin
            logic stb, other;
            guard++;
            len++;
            stb   = v.wr ? !wr_n : !rd_n;
            other = v.wr ? !rd_n : !wr_n;
            if (ale) ale_c++;
            if (other) bad++;
            if (addr_hi_oe !== v.hi || addr_hi_o !== v.addr[15:8]) bad++;
            if (v.sep) begin
                if (!addr_lo_oe || addr_lo_o !== v.addr[7:0] || ale) bad++;
            end else if (addr_lo_oe) bad++;
            if (stb) begin
                seen = 1'b1;
                stw++;
            end else if (!seen) begin
                pre++;
            end
            if (!v.sep && !seen) begin
                if (!ad_oe || ad_o !== v.addr[7:0]) bad++;
            end else if (v.wr) begin
                if (!ad_oe || ad_o !== v.wd) bad++;
            end else if (ad_oe) bad++;
            @(negedge clk);
        end
        chk(len == len_e, $sformatf("R5/R6 vec%0d cycle length", idx), len, len_e);
        chk(ale_c == ale_e, $sformatf("R2 vec%0d ale high clocks", idx), ale_c, ale_e);
        chk(pre == pre_e, $sformatf("R3 vec%0d clocks before strobe", idx), pre, pre_e);
        chk(stw == stw_e, $sformatf("R4 vec%0d strobe width", idx), stw, stw_e);
        chk(bad == 0, $sformatf("R2/R7/R8/R10 vec%0d pin rule violations", idx), bad, 0);
        if (v.wr) chk(done === 1'b1, $sformatf("R9 vec%0d done after write", idx), done, 1);
        else chk(done === 1'b1 && rdata === v.rv,
                 $sformatf("R7 vec%0d read data at done", idx), rdata, v.rv);
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 200) begin
            g++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int cnt, ale_c, extra;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !ale && rd_n && wr_n && !ctl_oe && !addr_hi_oe
            && !addr_lo_oe && !ad_oe, "R1 reset idle outputs",
            {busy, ale, rd_n, wr_n, ctl_oe, ad_oe}, 6'b001100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !ctl_oe && !ad_oe, "R1 idle after reset release", busy, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end

        // R9: request during a busy cycle is ignored
        @(negedge clk);
        set_cfg('{1'b0, 2'd3, 2'd3, 4'd15, 2'd3, 1'b0, 1'b1, 16'h2468, 8'h00, 8'h5E});
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hBEEF; req_wdata = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk(done === 1'b1 && rdata === 8'h5E, "R9 first read survives mid-cycle request",
            rdata, 8'h5E);
        extra = 0;
        repeat (4) begin
            @(negedge clk);
            if (busy || ale || !wr_n) extra++;
        end
        chk(extra == 0, "R9 mid-cycle request dropped", extra, 0);

        // R11: configuration changes during a cycle have no effect
        set_cfg('{1'b1, 2'd0, 2'd0, 4'd1, 2'd0, 1'b0, 1'b0, 16'h0101, 8'h00, 8'h77});
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_strobe = 4'd15; cfg_setup = 2'd3; cfg_sep = 1'b0; cfg_ale = 2'd3;
        cnt = 0; ale_c = 0;
        begin
            int g = 0;
            while (busy && g < 100) begin
                g++;
                if (!rd_n) cnt++;
                if (ale) ale_c++;
                @(negedge clk);
            end
        end
        chk(cnt == 2, "R11 strobe width frozen at acceptance", cnt, 2);
        chk(ale_c == 0 && rdata === 8'h77, "R11 mode frozen at acceptance", ale_c, 0);

        // R9: request held through done starts the next cycle at once
        set_cfg('{1'b1, 2'd0, 2'd0, 4'd0, 2'd0, 1'b1, 1'b0, 16'h0042, 8'h99, 8'h00});
        req_valid = 1'b1;
        @(negedge clk);
        wait_idle();
        chk(done === 1'b1 && busy === 1'b0, "R9 done pulse with busy low", done, 1);
        @(negedge clk);
        chk(busy === 1'b1 && done === 1'b0, "R9 back-to-back cycle starts", busy, 1);
        req_valid = 1'b0;
        wait_idle();
        @(negedge clk);
        chk(!done && !busy && !ctl_oe && !ad_oe && !addr_lo_oe, "R1 pins released after cycle",
            ad_oe, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule